// File: doc/BRIEF.md
# Synchronous Burst Static RAM Core

This block is a clocked single-port static RAM with four 9-bit byte lanes. It has a small burst engine of its own. On every rising clock edge it registers the address, the write data, three chip selects and its command inputs. A burst begins when either of two active-low address strobes is sampled low. One strobe is meant for a processor and the other for a cache or memory controller. While no strobe is present, a step input either moves the 2-bit burst counter forward or holds it in place.

The burst counter can follow a linear or an interleaved order, chosen at run time. A write can cover every lane at once or only selected lanes. Read data can be presented in two ways:

- **Flow-through:** the data comes straight from the array in the cycle after the command edge.
- **Pipelined:** the data passes through an output register and arrives one edge later.

The shared data bus is split into a data input, a data output and an output-drive flag. An asynchronous output-enable input can only suppress the drivers. A sleep input freezes the block while the array contents are kept.

Top module: `sync_burst_sram`

## Requirements
- R1: The chip is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A strobe sampled while the chip is selected loads the full external address, and its two low bits become the first burst address.
- R2: With no effective strobe during an active burst, `step_n`=0 moves to the next burst address and `step_n`=1 repeats the current address.
- R3: With `lin_order_n`=0, the low two address bits follow (start + n) mod 4 for beat n = 0..3.
- R4: With `lin_order_n`=1, the low two address bits follow start XOR n for beat n = 0..3.
- R5: After the fourth beat, a further step returns the burst to its start address. The upper address bits never change during a burst.
- R6: `proc_strb_n` has no effect while `sel_a_n`=1, and a burst in progress simply continues. A `ctl_strb_n` sampled low while the chip is not selected ends the burst (deselect). Cycles without a strobe then stay deselected.
- R7: A cycle started by `proc_strb_n` (with `sel_a_n`=0) is always a read, whatever the write inputs are.
- R8: In controller-started or continuing cycles, `wr_all_n`=0 writes all four lanes. Otherwise `wr_byte_n`=0 writes exactly the lanes whose `lane_n` bit is 0, where bit k controls `din[9k+8:9k]`. `wr_byte_n`=1, or `lane_n`=4'hF, makes the cycle a read.
- R9: Reads drive all lanes. `dout_en` is 0 for every cycle slot that belongs to a write.
- R10: With `pipe_mode`=0, read data and `dout_en` appear after the command edge. With `pipe_mode`=1, they appear after the next edge.
- R11: After a deselect is captured, drivers turn off in the very next output slot. That slot is after the capturing edge in flow-through mode and after the following edge in pipelined mode.
- R12: `out_en_n`=1 forces `dout_en` to 0 at once, without waiting for a clock. `out_en_n`=0 enables drivers only in a read output slot.
- R13: While `sleep_req`=1, all commands are ignored, array contents and burst state are kept, and `dout_en` is 0. Normal operation resumes at the first edge after release.
- R14: Reset (`rst_n`=0) clears the burst state, the output register and the drive pipeline, so `dout_en`=0 and `dout`=0. Whenever `dout_en`=0, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Standby request, active high |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| pipe_mode | input | 1 | 1 = pipelined output, 0 = flow-through |
| lin_order_n | input | 1 | 0 = linear burst order, 1 = interleaved |
| sel_a_n | input | 1 | Chip select, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| proc_strb_n | input | 1 | Processor address strobe, active low |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write every lane, active low |
| wr_byte_n | input | 1 | Lane write enable, active low |
| lane_n | input | LANES | Per-lane write select, active low |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data, zero when not driving |
| dout_en | output | 1 | Bus drive flag |

## Verification
A burst step and a new strobe can arrive in the same cycle. The bench provokes this by asserting `proc_strb_n` with `sel_a_n` high during an active burst while `step_n` is low, and by mixing strobes with active write inputs. The expected outcome is the one the reference model gives from the priority rules.

The asynchronous output enable and sleep can also change in the middle of a read slot. The bench toggles them between clock edges, and the bus flag is compared against the model right after each change.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep_req,
  input  logic                    out_en_n,
  input  logic                    pipe_mode,
  input  logic                    lin_order_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    proc_strb_n,
  input  logic                    ctl_strb_n,
  input  logic                    step_n,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [LANES-1:0]        lane_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              burst_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic              rd_q;
  logic [ADDR_W-1:0] ra_q;
  logic              pen_q;
  logic [DATA_W-1:0] pdq_q;
  logic [DATA_W-1:0] flow_dat;

  wire chip_on  = !sel_a_n & sel_b & !sel_c_n;
  wire p_start  = !proc_strb_n & !sel_a_n;
  wire start    = p_start | !ctl_strb_n;

  wire [LANES-1:0] lane_wr = !wr_all_n ? {LANES{1'b1}} :
                             (!wr_byte_n ? ~lane_n : {LANES{1'b0}});

  wire [1:0]        cnt_nx = start ? 2'd0 : cnt_q + {1'b0, !step_n};
  wire [ADDR_W-1:0] seed   = start ? addr : base_q;
  wire [1:0]        low    = lin_order_n ? (seed[1:0] ^ cnt_nx) : (seed[1:0] + cnt_nx);
  wire [ADDR_W-1:0] acc_a  = {seed[ADDR_W-1:2], low};

  wire acc   = !sleep_req & (start ? chip_on : burst_q);
  wire is_wr = acc & !p_start & (|lane_wr);
  wire is_rd = acc & !is_wr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] ram [DEPTH];
    always_ff @(posedge clk)
      if (is_wr && lane_wr[g]) ram[acc_a] <= din[g*LANE_W +: LANE_W];
    assign flow_dat[g*LANE_W +: LANE_W] = ram[ra_q];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_q <= 1'b0;
      base_q  <= '0;
      cnt_q   <= 2'd0;
      rd_q    <= 1'b0;
      ra_q    <= '0;
      pen_q   <= 1'b0;
      pdq_q   <= '0;
    end else begin
      pen_q <= rd_q;
      if (rd_q) pdq_q <= flow_dat;
      rd_q <= is_rd;
      if (is_rd) ra_q <= acc_a;
      if (!sleep_req) begin
        if (start) begin
          burst_q <= chip_on;
          if (chip_on) begin
            base_q <= addr;
            cnt_q  <= 2'd0;
          end
        end else if (burst_q) begin
          cnt_q <= cnt_nx;
        end
      end
    end
  end

  assign dout_en = (pipe_mode ? pen_q : rd_q) & !out_en_n & !sleep_req;
  assign dout    = dout_en ? (pipe_mode ? pdq_q : flow_dat) : '0;
endmodule

module sync_burst_sram_chk #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sleep_req,
  input logic                    out_en_n,
  input logic                    pipe_mode,
  input logic                    lin_order_n,
  input logic                    sel_a_n,
  input logic                    sel_b,
  input logic                    sel_c_n,
  input logic                    proc_strb_n,
  input logic                    ctl_strb_n,
  input logic                    step_n,
  input logic                    wr_all_n,
  input logic                    wr_byte_n,
  input logic [LANES-1:0]        lane_n,
  input logic [ADDR_W-1:0]       addr,
  input logic [LANES*LANE_W-1:0] din,
  input logic [LANES*LANE_W-1:0] dout,
  input logic                    dout_en
);
  wire sel_ok   = !sel_a_n && sel_b && !sel_c_n;
  wire ctl_only = !sleep_req && !ctl_strb_n && (proc_strb_n || sel_a_n);
  wire prc_go   = !sleep_req && !proc_strb_n && sel_ok;

  a_r12_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !dout_en);

  a_r13_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> !dout_en);

  a_r9_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_only && sel_ok && !wr_all_n && !pipe_mode) |=> (pipe_mode || !dout_en));

  a_r11_desel_flow: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_only && !sel_ok && !pipe_mode) |=> (pipe_mode || !dout_en));

  a_r11_desel_pipe: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_only && !sel_ok && pipe_mode) |=> ##1 (!pipe_mode || !dout_en));

  a_r7_proc_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (prc_go && !pipe_mode) |=> (pipe_mode || out_en_n || sleep_req || dout_en));

  a_r10_pipe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (prc_go && pipe_mode) |=> ##1 (!pipe_mode || out_en_n || sleep_req || dout_en));

  a_r14_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dout_en) |-> (dout == '0));
endmodule

bind sync_burst_sram sync_burst_sram_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
) u_chk (.*);

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic clk = 1'b0;
  logic rst_n, sleep_req, out_en_n, pipe_mode, lin_order_n;
  logic sel_a_n, sel_b, sel_c_n, proc_strb_n, ctl_strb_n, step_n;
  logic wr_all_n, wr_byte_n;
  logic [NL-1:0] lane_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic dout_en;

  sync_burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) i_sync_burst_sram (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  string tag = "R14";

  logic [DW-1:0] m_mem [1<<AW];
  int  m_base, m_cnt, m_acc;
  bit  m_burst, m_rd, m_pen;
  logic [DW-1:0] m_pdq;

  task automatic chk(string t, logic [DW:0] act, logic [DW:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  function automatic logic [DW:0] expect_out();
    bit en;
    logic [DW-1:0] d;
    en = (pipe_mode ? m_pen : m_rd) && !out_en_n && !sleep_req && rst_n;
    d  = pipe_mode ? m_pdq : m_mem[m_acc];
    return en ? {1'b1, d} : {1'b0, {DW{1'b0}}};
  endfunction

  task automatic model_edge();
    int kind, lo, a;
    bit on;
    logic [NL-1:0] lanes;
    if (!rst_n) begin
      m_burst = 0; m_rd = 0; m_pen = 0; m_pdq = '0; m_cnt = 0; m_base = 0; m_acc = 0;
      return;
    end
    if (m_rd) m_pdq = m_mem[m_acc];
    m_pen = m_rd;
    if (sleep_req) begin m_rd = 0; return; end
    on = !sel_a_n && sel_b && !sel_c_n;
    if (!proc_strb_n && !sel_a_n) kind = 1;
    else if (!ctl_strb_n) kind = 2;
    else kind = 0;
    lanes = !wr_all_n ? 4'hF : (!wr_byte_n ? ~lane_n : 4'h0);
    if (kind != 0) begin
      if (!on) begin m_burst = 0; m_rd = 0; return; end
      m_burst = 1; m_base = addr; m_cnt = 0;
    end else if (!m_burst) begin
      m_rd = 0; return;
    end else if (!step_n) begin
      m_cnt = (m_cnt + 1) % 4;
    end
    lo = m_base % 4;
    lo = lin_order_n ? (lo ^ m_cnt) : ((lo + m_cnt) % 4);
    a  = (m_base / 4) * 4 + lo;
    if (kind != 1 && lanes != 0) begin
      for (int l = 0; l < NL; l++)
        if (lanes[l]) m_mem[a][l*LW +: LW] = din[l*LW +: LW];
      m_rd = 0;
    end else begin
      m_rd = 1; m_acc = a;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, {dout_en, dout}, expect_out());
  endtask

  task automatic quiet();
    proc_strb_n = 1; ctl_strb_n = 1; step_n = 1;
    wr_all_n = 1; wr_byte_n = 1; lane_n = '1;
    sel_a_n = 0; sel_b = 1; sel_c_n = 0; din = '0;
  endtask

  task automatic desel();
    quiet(); ctl_strb_n = 0; sel_b = 0; step(); quiet();
  endtask

  task automatic proc_rd(int a);
    quiet(); proc_strb_n = 0; addr = AW'(a); step(); quiet();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; sleep_req = 0; out_en_n = 0; pipe_mode = 0; lin_order_n = 1;
    addr = '0; quiet();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R14", {dout_en, dout}, {1'b0, {DW{1'b0}}});
    model_edge();
    rst_n = 1;

    tag = "R8";
    for (int a = 0; a < (1 << AW); a++) begin
      quiet(); ctl_strb_n = 0; wr_all_n = 0; addr = AW'(a);
      din = {4{LW'(a * 7 + 3)}} ^ DW'(a << 20);
      step();
    end
    desel();
    quiet(); ctl_strb_n = 0; wr_byte_n = 0; lane_n = 4'b1010; addr = 6'd2;
    din = 36'h1_2345_6789; step();
    quiet(); ctl_strb_n = 0; wr_byte_n = 0; lane_n = 4'b0111; wr_all_n = 1; addr = 6'd3;
    din = 36'hA_BCDE_F012; step();
    tag = "R9";
    quiet(); ctl_strb_n = 0; wr_all_n = 0; lane_n = 4'hF; addr = 6'd4;
    din = 36'h5_5555_5555; step();
    tag = "R8";
    quiet(); ctl_strb_n = 0; wr_byte_n = 1; lane_n = 4'h0; addr = 6'd5; step();
    quiet(); ctl_strb_n = 0; wr_byte_n = 0; lane_n = 4'hF; addr = 6'd6; step();
    desel();

    tag = "R1";
    proc_rd(2);
    chk("R1", {dout_en, dout}, {1'b1, m_mem[2]});
    proc_rd(3);
    quiet(); sel_c_n = 1; proc_strb_n = 0; addr = 6'd9; step();
    quiet(); ctl_strb_n = 0; addr = 6'd4; step();

    tag = "R3"; lin_order_n = 0;
    proc_rd(14);
    tag = "R2";
    for (int i = 0; i < 3; i++) begin step_n = 0; step(); end
    step_n = 1; step(); step();
    tag = "R5";
    step_n = 0; step(); step_n = 0; step();
    chk("R5", {dout_en, dout}, {1'b1, m_mem[15]});

    tag = "R4"; lin_order_n = 1;
    proc_rd(21);
    for (int i = 0; i < 5; i++) begin step_n = 0; step(); end
    chk("R4", {dout_en, dout}, {1'b1, m_mem[20]});

    tag = "R8";
    quiet(); ctl_strb_n = 0; wr_all_n = 0; addr = 6'd32; din = 36'h0_0000_0111; step();
    for (int i = 0; i < 3; i++) begin
      quiet(); step_n = 0; wr_byte_n = 0; lane_n = 4'b1100; din = DW'(36'h0_0F0F_0F0F + i); step();
    end
    lin_order_n = 0;
    proc_rd(32);
    for (int i = 0; i < 3; i++) begin step_n = 0; step(); end

    tag = "R6";
    proc_rd(40);
    quiet(); sel_a_n = 1; proc_strb_n = 0; step_n = 0; addr = 6'd50; step();
    quiet(); sel_a_n = 1; proc_strb_n = 0; ctl_strb_n = 0; addr = 6'd44;
    wr_all_n = 0; din = 36'h9_8765_4321; step();
    quiet(); ctl_strb_n = 0; sel_c_n = 1; step();
    quiet(); step(); step_n = 0; step();
    chk("R6", {dout_en, dout}, {1'b0, {DW{1'b0}}});

    tag = "R7";
    quiet(); proc_strb_n = 0; ctl_strb_n = 0; wr_all_n = 0; addr = 6'd7;
    din = 36'hF_FFFF_FFFF; step();
    chk("R7", {dout_en, dout}, {1'b1, m_mem[7]});
    desel();

    tag = "R10"; pipe_mode = 1;
    @(negedge clk);
    proc_rd(11);
    chk("R10", {dout_en, dout}, {1'b0, {DW{1'b0}}});
    step_n = 0; step();
    chk("R10", {dout_en, dout}, {1'b1, m_mem[11]});
    step(); step();
    tag = "R11";
    desel();
    chk("R11", dout_en, 1'b1);
    step();
    chk("R11", dout_en, 1'b0);
    tag = "R9";
    proc_rd(12);
    quiet(); ctl_strb_n = 0; wr_all_n = 0; addr = 6'd13; din = 36'h3_3333_3333; step();
    quiet(); step(); step();

    tag = "R12";
    pipe_mode = 0;
    proc_rd(13);
    out_en_n = 1; #1;
    chk("R12", {dout_en, dout}, expect_out());
    chk("R12", dout_en, 1'b0);
    out_en_n = 0; #1;
    chk("R12", dout_en, 1'b1);
    desel();
    chk("R12", dout_en, 1'b0);

    tag = "R13";
    proc_rd(1);
    sleep_req = 1; #1;
    chk("R13", dout_en, 1'b0);
    quiet(); ctl_strb_n = 0; wr_all_n = 0; addr = 6'd1; din = 36'h0_DEAD_BEEF; step();
    quiet(); proc_strb_n = 0; addr = 6'd30; step();
    sleep_req = 0; quiet(); step();
    chk("R13", {dout_en, dout}, {1'b1, m_mem[1]});
    proc_rd(1);
    desel();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule